// File: doc/BRIEF.md
# Dual-Select Nibble Static Memory

This block is a small word-addressed storage array with a 4-bit input bus and a separate 4-bit output bus. Two chip selects of opposite polarity gate it: `chipSelN` is active low and `chipSel` is active high. The block counts as selected only when both are asserted. An active-low write enable and an active-low output enable then choose between storing a word, driving a stored word, and leaving the output idle.

The output bus stands in for a tri-state driver. `dataOut` carries the value and `dataOutEn` says whether that value is being driven. A consumer treats the data as high impedance whenever the enable is low. Writes take effect on the rising clock edge while the write condition holds. Reads are combinational from the array, so a word written at an edge can be read back in the cycle that follows, and that read returns the new value.

Top module: `nibble_sram`

## Requirements
- R1: After reset every word holds 0 and `dataOutEn` is 0 until a read condition is applied.
- R2: When `chipSelN`=0, `chipSel`=1 and `wrEnN`=0 at a rising edge, `dataIn` is stored at `addr`. The level of `outEnN` makes no difference to the write.
- R3: When `chipSelN`=0, `chipSel`=1, `wrEnN`=1 and `outEnN`=0, `dataOutEn` is 1 and `dataOut` equals the stored word at `addr`, without inversion, in the same cycle.
- R4: When `chipSelN`=1 or `chipSel`=0, `dataOutEn` is 0 and no word changes, whatever `wrEnN` is.
- R5: While the block is selected with `wrEnN`=0, `dataOutEn` is 0.
- R6: When the block is selected with `wrEnN`=1 and `outEnN`=1, `dataOutEn` is 0 and no word changes.
- R7: In the cycle right after a write, a read of the same address returns the value just written.
- R8: `dataOut` is 0 whenever `dataOutEn` is 0.
- R9: A write changes only the addressed word. Every other word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset; clears the array |
| addr | input | 8 | Word address |
| dataIn | input | 4 | Write data |
| chipSelN | input | 1 | Active-low chip select |
| chipSel | input | 1 | Active-high chip select |
| wrEnN | input | 1 | Active-low write enable |
| outEnN | input | 1 | Active-low output enable |
| dataOut | output | 4 | Read data; 0 when not driven |
| dataOutEn | output | 1 | Drive flag for `dataOut`; low means high impedance |

## Verification
Some properties are checked by assertions on every cycle:
- the output is never driven while the block is deselected or writing;
- an undriven output reads as 0;
- the word at the write address takes the written value;
- the addressed word stays put when no write strobe is present;
- a read of the same address just after a write returns that write's data.

Other behaviour needs the bench's scenarios, which compare every cycle against a behavioural model. These scenarios cover:
- the cleared contents across the whole address space after reset;
- writes that are blocked by either select;
- writes made with `outEnN` low;
- the absence of aliasing between neighbouring and distant addresses.

// File: rtl/nibble_sram_pkg.sv
package nibble_sram_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_OUTOFF  = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } memMode_t;

  typedef struct packed {
    logic wrStrobe;
    logic rdDrive;
  } ctrlStrobes_t;

endpackage

// File: rtl/nibble_sram_ctrl.sv
module nibble_sram_ctrl
  import nibble_sram_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         chipSelN,
  input  logic         chipSel,
  input  logic         wrEnN,
  input  logic         outEnN,
  output ctrlStrobes_t strb
);

  logic     selected;
  memMode_t mode;

  assign selected = !chipSelN && chipSel;

  always_comb begin
    if (!selected)   mode = MODE_STANDBY;
    else if (!wrEnN) mode = MODE_WRITE;
    else if (outEnN) mode = MODE_OUTOFF;
    else             mode = MODE_READ;
  end

  always_comb begin
    strb          = '0;
    strb.wrStrobe = (mode == MODE_WRITE);
    strb.rdDrive  = (mode == MODE_READ);
  end

  // R4: deselection blocks both write and drive
  p_deselect_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (chipSelN || !chipSel) |-> !(strb.wrStrobe || strb.rdDrive));

  // R5: a write never drives the output
  p_write_float_r5: assert property (@(posedge clk) disable iff (!rstN)
    !wrEnN |-> !strb.rdDrive);

  // R6: output-off mode neither writes nor drives
  p_outoff_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEnN && outEnN) |-> !(strb.wrStrobe || strb.rdDrive));

endmodule

// File: rtl/nibble_sram_dpath.sv
module nibble_sram_dpath
  import nibble_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrlStrobes_t      strb,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] storage [DEPTH];
  logic [DEPTH-1:0]  wordSel;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    assign wordSel[w] = strb.wrStrobe && (addr == ADDR_W'(w));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           storage[w] <= '0;
      else if (wordSel[w]) storage[w] <= dataIn;
    end
  end

  assign dataOutEn = strb.rdDrive;
  assign dataOut   = strb.rdDrive ? storage[addr] : '0;

  // R2: the addressed word takes the written value
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStrobe |=> storage[$past(addr)] == $past(dataIn));

  // R9 / R6: without a write strobe the addressed word keeps its value
  p_no_write_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrStrobe |=> storage[$past(addr)] == $past(storage[addr]));

  // R7: a same-address read right after a write returns the new data
  p_post_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStrobe |=> (!(strb.rdDrive && addr == $past(addr)) || dataOut == $past(dataIn)));

  // R8: an undriven output reads as zero
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !dataOutEn |-> dataOut == '0);

  // At most one word is written per cycle
  p_one_word_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wordSel));

endmodule

// File: rtl/nibble_sram.sv
module nibble_sram
  import nibble_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              chipSelN,
  input  logic              chipSel,
  input  logic              wrEnN,
  input  logic              outEnN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);

  ctrlStrobes_t strb;

  nibble_sram_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .chipSelN (chipSelN),
    .chipSel  (chipSel),
    .wrEnN    (wrEnN),
    .outEnN   (outEnN),
    .strb     (strb)
  );

  nibble_sram_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .dataIn    (dataIn),
    .strb      (strb),
    .dataOut   (dataOut),
    .dataOutEn (dataOutEn)
  );

  // R4 / R5: the output floats when deselected or writing
  p_port_float_r4: assert property (@(posedge clk) disable iff (!rstN)
    (chipSelN || !chipSel || !wrEnN) |-> !dataOutEn);

  // R3: a full read condition drives the bus
  p_port_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSelN && chipSel && wrEnN && !outEnN) |-> dataOutEn);

endmodule

// File: tb/nibble_sram_tb_top.sv
`timescale 1ns/1ps
module nibble_sram_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] addr = '0;
  logic [3:0] dataIn = '0;
  logic       chipSelN = 1'b1;
  logic       chipSel = 1'b0;
  logic       wrEnN = 1'b1;
  logic       outEnN = 1'b1;
  logic [3:0] dataOut;
  logic       dataOutEn;

  int checks = 0;
  int errors = 0;
  int refMem [256];
  bit done = 0;

  always #2.5 clk = ~clk;

  nibble_sram dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn),
    .chipSelN(chipSelN), .chipSel(chipSel), .wrEnN(wrEnN), .outEnN(outEnN),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  task automatic check(string tag, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // One cycle: drive after the falling edge, compare, then commit the model at the rising edge
  task automatic step(bit cs1, bit cs2, bit we, bit oe, int a, int d, string tag);
    bit sel, expEn;
    int expData;
    @(negedge clk);
    chipSelN = cs1; chipSel = cs2; wrEnN = we; outEnN = oe;
    addr = 8'(a); dataIn = 4'(d);
    #1;
    sel     = !cs1 && cs2;
    expEn   = sel && we && !oe;
    expData = expEn ? refMem[a] : 0;
    check(tag, int'(dataOutEn), int'(expEn), "dataOutEn");
    check(tag, int'(dataOut), expData, "dataOut");
    @(posedge clk);
    if (sel && !we) refMem[a] = d;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) refMem[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(dataOutEn), 0, "dataOutEn in reset");
    @(negedge clk);
    rstN = 1'b1;

    // R1: cleared array across the whole address space
    for (int i = 0; i < 256; i++) step(0, 1, 1, 0, i, 0, "R1");

    // R2: writes with outEnN high and low, then read back (R3)
    step(0, 1, 0, 1, 8'h10, 4'hA, "R2");
    step(0, 1, 0, 0, 8'h11, 4'h5, "R2");
    step(0, 1, 1, 0, 8'h10, 0, "R3");
    step(0, 1, 1, 0, 8'h11, 0, "R3");

    // R7: read of the same address in the cycle right after a write
    step(0, 1, 0, 0, 8'h20, 4'hC, "R5");
    step(0, 1, 1, 0, 8'h20, 0, "R7");
    step(0, 1, 0, 1, 8'h20, 4'h3, "R5");
    step(0, 1, 1, 0, 8'h20, 0, "R7");

    // R4: writes blocked by each select, then read back
    step(1, 1, 0, 0, 8'h30, 4'hF, "R4");
    step(0, 0, 0, 0, 8'h30, 4'hE, "R4");
    step(1, 0, 0, 1, 8'h30, 4'hD, "R4");
    step(1, 1, 1, 0, 8'h10, 0, "R4");
    step(0, 1, 1, 0, 8'h30, 0, "R4");

    // R6 / R8: output-off mode, then contents are unchanged
    step(0, 1, 1, 1, 8'h10, 4'h7, "R6");
    step(0, 1, 1, 1, 8'h11, 4'h7, "R8");
    step(0, 1, 1, 0, 8'h10, 0, "R6");

    // R9: boundary and neighbouring addresses do not alias
    step(0, 1, 0, 1, 8'h00, 4'h1, "R9");
    step(0, 1, 0, 1, 8'hFF, 4'hE, "R9");
    step(0, 1, 0, 1, 8'h80, 4'h9, "R9");
    step(0, 1, 0, 1, 8'h7F, 4'h6, "R9");
    for (int i = 0; i < 256; i++) step(0, 1, 1, 0, i, 0, "R9");

    // Mixed traffic: an address-dependent pattern over all modes
    for (int i = 0; i < 400; i++) begin
      int a = (i * 37 + 11) % 256;
      int d = (i * 7 + 3) % 16;
      int m = i % 5;
      case (m)
        0: step(0, 1, 0, i % 2, a, d, "R2");
        1: step(0, 1, 1, 0, a, 0, "R3");
        2: step(0, 1, 1, 1, a, d, "R6");
        3: step(1, i % 2, 0, 0, a, d, "R4");
        default: step(0, 1, 1, 0, (a + 1) % 256, 0, "R9");
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule